// File: doc/BRIEF.md
# Banked Scratchpad Conflict Replay Unit

This unit sits in front of a scratchpad made of 32 word-wide banks, each word four bytes. One warp presents up to 32 thread byte addresses together with an active mask, an element size and a read/write flag. The unit finds out which threads collide on a bank with different words. It then serves the access as a sequence of conflict-free passes. In a pass each bank delivers or accepts one word, and that word goes to every pending thread that asked for it.

Elements wider than a word occupy two or four consecutive banks and are served in sub-warp phases: 16 threads at a time for 8-byte elements and 8 threads at a time for 16-byte elements. Only threads in the same phase compete for a bank. Each pass drives a bank-enable vector, the row to use in every enabled bank, the thread that owns each enabled bank, the current phase, and a strobe per thread. When several threads write one word in a pass, the highest-numbered of them owns the bank. For a read, the lowest-numbered one owns it.

Top module: `sbank_conflict_replay`

## Requirements
- R1: For a thread, word = byte address / 4, bank = word mod 32 and row = word / 32. For each enabled bank, `bank_row` carries that row in bits [b*7 +: 7].
- R2: Threads whose addresses fall in the same word are all served in the same pass, whatever byte inside the word each one uses.
- R3: A bank is enabled in a pass only when a pending thread of the current phase touches it. Within a phase, each bank serves the row of the lowest-numbered pending thread that touches it, together with every pending thread that wants that same row.
- R4: For elements of 4 bytes or less, the number of passes equals the largest count of distinct words that active threads request in any single bank. An N-way conflict therefore takes N passes.
- R5: `req_size` encoding: 0 means 4 bytes or less, with one phase of 32 threads. 1 means 8 bytes, with two phases of 16 threads. 2 and 3 mean 16 bytes, with four phases of 8 threads. Phase p holds threads p*T to p*T+T-1, where T is the number of threads per phase. Phases run in ascending order, and `pass_phase` reports the current one.
- R6: An element of 2^k words uses the 2^k consecutive banks that start at its word rounded down to a multiple of 2^k. Address bits below the element size are ignored. Threads in different phases never conflict.
- R7: Threads whose mask bit is 0 are never strobed and enable no bank.
- R8: `bank_owner` bits [b*5 +: 5] hold a thread number. On a write this is the highest-numbered thread served in bank b during the pass. On a read it is the lowest-numbered one. A bank that is not enabled reads 0.
- R9: Each active thread is strobed exactly once per request. `done` is high in the cycle of the last pass. A request whose mask is all zero gives `done` one cycle after acceptance, with no pass.
- R10: `req_ready` is low from acceptance until the cycle after `done`. A `req_valid` seen in that window is ignored.
- R11: After reset the unit is idle: `req_ready` is 1, and `pass_valid`, `done`, `bank_en` and `thread_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; accepted when req_ready is high |
| req_ready | output | 1 | Unit idle and able to accept a request |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_size | input | 2 | Element size code (see R5) |
| req_mask | input | 32 | Active thread mask |
| req_addr | input | 448 | Byte address per thread; thread t in bits [t*14 +: 14] |
| pass_valid | output | 1 | A pass is being issued in this cycle |
| pass_phase | output | 2 | Phase the current pass belongs to |
| bank_en | output | 32 | Banks active in this pass |
| bank_row | output | 224 | Row per bank, 7 bits each |
| bank_owner | output | 160 | Owning thread per bank, 5 bits each |
| thread_valid | output | 32 | Threads served in this pass |
| done | output | 1 | Last cycle of the request |

## Verification
A request is accepted at the rising edge where both `req_valid` and `req_ready` are high. The first pass is visible for the whole clock period that follows that edge. After that, one pass appears per cycle, with `done` in the last of them, and `req_ready` comes back one edge later. The scoreboard is filled with the full ordered list of passes before the request is driven. The monitor samples at every falling edge and removes one entry for each cycle with `pass_valid` high, so a pass that comes a cycle late or early shows up as a mismatch in order or in count. After `done`, the bench checks that the queue is empty and that the unit stays idle.

// File: rtl/sbank_pkg.sv
package sbank_pkg;

    localparam int THREADS    = 32;
    localparam int BANKS      = 32;
    localparam int WORD_BYTES = 4;
    localparam int ADDR_W     = 14;

    localparam int TID_W  = $clog2(THREADS);
    localparam int BANK_W = $clog2(BANKS);
    localparam int OFF_W  = $clog2(WORD_BYTES);
    localparam int WORD_W = ADDR_W - OFF_W;
    localparam int ROW_W  = WORD_W - BANK_W;
    localparam int MAX_WL = 2;
    localparam int PH_W   = MAX_WL;

    typedef enum logic [1:0] {
        SZ_WORD  = 2'd0,
        SZ_DWORD = 2'd1,
        SZ_QWORD = 2'd2,
        SZ_QALT  = 2'd3
    } elem_size_e;

    typedef struct packed {
        logic [BANK_W-1:0] grp_bank;
        logic [ROW_W-1:0]  row;
        logic [PH_W-1:0]   phase;
    } slot_t;

    // log2 of the number of words one element covers
    function automatic logic [1:0] words_log2(input elem_size_e sz);
        case (sz)
            SZ_WORD:  return 2'd0;
            SZ_DWORD: return 2'd1;
            default:  return 2'd2;
        endcase
    endfunction

    // first bank of the group of 2^wl banks that holds a given bank
    function automatic logic [BANK_W-1:0] group_base(input logic [BANK_W-1:0] bank,
                                                     input logic [1:0] wl);
        logic [BANK_W-1:0] keep;
        keep = {BANK_W{1'b1}} << wl;
        return bank & keep;
    endfunction

endpackage

// File: rtl/sbank_slot_decode.sv
module sbank_slot_decode
    import sbank_pkg::*;
(
    input  logic [THREADS*ADDR_W-1:0] addr_flat,
    input  logic [1:0]                wl,
    output slot_t                     slots [THREADS]
);

    logic [2:0] ph_shift;
    assign ph_shift = 3'(TID_W) - {1'b0, wl};

    for (genvar t = 0; t < THREADS; t++) begin : g_thr
        logic [WORD_W-1:0] word;
        logic [TID_W-1:0]  tid;
        assign word = addr_flat[t*ADDR_W+OFF_W +: WORD_W];
        assign tid  = TID_W'(t);
        assign slots[t] = '{
            grp_bank: group_base(word[BANK_W-1:0], wl),
            row:      word[WORD_W-1:BANK_W],
            phase:    PH_W'(tid >> ph_shift)
        };
    end

endmodule

// File: rtl/sbank_pass_select.sv
module sbank_pass_select
    import sbank_pkg::*;
(
    input  slot_t               slots [THREADS],
    input  logic [THREADS-1:0]  pending,
    input  logic [1:0]          wl,
    input  logic                write,
    output logic [THREADS-1:0]  served,
    output logic [BANKS-1:0]    bank_en,
    output logic [ROW_W-1:0]    bank_row [BANKS],
    output logic [TID_W-1:0]    bank_owner [BANKS],
    output logic [PH_W-1:0]     cur_phase
);

    logic [THREADS-1:0] cand;

    // Current phase follows the lowest pending thread, since threads
    // retire in ascending phase order.
    always_comb begin
        logic found;
        found     = 1'b0;
        cur_phase = '0;
        for (int t = 0; t < THREADS; t++) begin
            if (pending[t] && !found) begin
                found     = 1'b1;
                cur_phase = slots[t].phase;
            end
        end
        for (int t = 0; t < THREADS; t++) begin
            cand[t] = pending[t] && (slots[t].phase == cur_phase);
        end
    end

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic [THREADS-1:0] touch;
        logic               hit;
        logic [ROW_W-1:0]   win_row;
        logic [TID_W-1:0]   own;

        always_comb begin
            for (int t = 0; t < THREADS; t++) begin
                touch[t] = (slots[t].grp_bank == group_base(BANK_W'(b), wl));
            end
        end

        // winner row: the one asked for by the lowest candidate in this bank
        always_comb begin
            hit     = 1'b0;
            win_row = '0;
            for (int t = 0; t < THREADS; t++) begin
                if (cand[t] && touch[t] && !hit) begin
                    hit     = 1'b1;
                    win_row = slots[t].row;
                end
            end
        end

        // owner: last served thread on a write, first on a read
        always_comb begin
            logic got;
            got = 1'b0;
            own = '0;
            for (int t = 0; t < THREADS; t++) begin
                if (served[t] && touch[t]) begin
                    if (write || !got) begin
                        own = TID_W'(t);
                    end
                    got = 1'b1;
                end
            end
        end

        assign bank_en[b]    = hit;
        assign bank_row[b]   = win_row;
        assign bank_owner[b] = own;
    end

    always_comb begin
        for (int t = 0; t < THREADS; t++) begin
            served[t] = cand[t] && (slots[t].row == bank_row[slots[t].grp_bank]);
        end
    end

endmodule

// File: rtl/sbank_replay_ctrl.sv
module sbank_replay_ctrl
    import sbank_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      req_valid,
    input  logic                      req_write,
    input  logic [1:0]                req_size,
    input  logic [THREADS-1:0]        req_mask,
    input  logic [THREADS*ADDR_W-1:0] req_addr,
    input  logic [THREADS-1:0]        served,
    output logic                      req_ready,
    output logic [THREADS-1:0]        pending_q,
    output logic [THREADS*ADDR_W-1:0] addr_q,
    output logic                      write_q,
    output logic [1:0]                wl_q,
    output logic                      pass_valid,
    output logic                      done
);

    logic               busy_q;
    logic [THREADS-1:0] remain;

    assign remain = pending_q & ~served;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q    <= 1'b0;
            pending_q <= '0;
            addr_q    <= '0;
            write_q   <= 1'b0;
            wl_q      <= '0;
        end else if (!busy_q) begin
            if (req_valid) begin
                busy_q    <= 1'b1;
                pending_q <= req_mask;
                addr_q    <= req_addr;
                write_q   <= req_write;
                wl_q      <= words_log2(elem_size_e'(req_size));
            end
        end else begin
            pending_q <= remain;
            if (remain == '0) begin
                busy_q <= 1'b0;
            end
        end
    end

    assign req_ready  = !busy_q;
    assign pass_valid = busy_q && (pending_q != '0);
    assign done       = busy_q && (remain == '0);

endmodule

// File: rtl/sbank_conflict_replay.sv
module sbank_conflict_replay
    import sbank_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic                      req_write,
    input  logic [1:0]                req_size,
    input  logic [THREADS-1:0]        req_mask,
    input  logic [THREADS*ADDR_W-1:0] req_addr,
    output logic                      pass_valid,
    output logic [PH_W-1:0]           pass_phase,
    output logic [BANKS-1:0]          bank_en,
    output logic [BANKS*ROW_W-1:0]    bank_row,
    output logic [BANKS*TID_W-1:0]    bank_owner,
    output logic [THREADS-1:0]        thread_valid,
    output logic                      done
);

    logic [THREADS-1:0]        pending_q;
    logic [THREADS*ADDR_W-1:0] addr_q;
    logic                      write_q;
    logic [1:0]                wl_q;
    logic [THREADS-1:0]        served;
    slot_t                     slots [THREADS];
    logic [ROW_W-1:0]          row_arr [BANKS];
    logic [TID_W-1:0]          own_arr [BANKS];

    sbank_replay_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_size   (req_size),
        .req_mask   (req_mask),
        .req_addr   (req_addr),
        .served     (served),
        .req_ready  (req_ready),
        .pending_q  (pending_q),
        .addr_q     (addr_q),
        .write_q    (write_q),
        .wl_q       (wl_q),
        .pass_valid (pass_valid),
        .done       (done)
    );

    sbank_slot_decode u_decode (
        .addr_flat (addr_q),
        .wl        (wl_q),
        .slots     (slots)
    );

    sbank_pass_select u_select (
        .slots      (slots),
        .pending    (pending_q),
        .wl         (wl_q),
        .write      (write_q),
        .served     (served),
        .bank_en    (bank_en),
        .bank_row   (row_arr),
        .bank_owner (own_arr),
        .cur_phase  (pass_phase)
    );

    for (genvar b = 0; b < BANKS; b++) begin : g_flat
        assign bank_row[b*ROW_W +: ROW_W]   = row_arr[b];
        assign bank_owner[b*TID_W +: TID_W] = own_arr[b];
    end

    assign thread_valid = served;

endmodule

// File: rtl/sbank_conflict_replay_chk.sv
module sbank_conflict_replay_chk
    import sbank_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic               req_ready,
    input logic [THREADS-1:0] req_mask,
    input logic               pass_valid,
    input logic [PH_W-1:0]    pass_phase,
    input logic [BANKS-1:0]   bank_en,
    input logic [THREADS-1:0] thread_valid,
    input logic               done
);

    logic [THREADS-1:0] mask_q;
    logic [THREADS-1:0] acc_q;
    logic [THREADS-1:0] strobe_now;

    assign strobe_now = pass_valid ? thread_valid : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            acc_q  <= '0;
        end else if (req_valid && req_ready) begin
            mask_q <= req_mask;
            acc_q  <= '0;
        end else begin
            acc_q <= acc_q | strobe_now;
        end
    end

    a_r11_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (req_ready && !pass_valid && !done));

    a_r7_inactive_never_strobed: assert property (@(posedge clk) disable iff (rst)
        pass_valid |-> ((thread_valid & ~mask_q) == '0));

    a_r9_strobed_once: assert property (@(posedge clk) disable iff (rst)
        pass_valid |-> ((thread_valid & acc_q) == '0));

    a_r9_done_covers_mask: assert property (@(posedge clk) disable iff (rst)
        done |-> ((acc_q | strobe_now) == mask_q));

    a_r9_ready_after_done: assert property (@(posedge clk) disable iff (rst)
        done |=> req_ready);

    a_r10_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
        pass_valid |-> !req_ready);

    a_r3_pass_not_empty: assert property (@(posedge clk) disable iff (rst)
        pass_valid |-> (thread_valid != '0 && bank_en != '0));

    a_r5_phase_ascending: assert property (@(posedge clk) disable iff (rst)
        (pass_valid && $past(pass_valid)) |-> (pass_phase >= $past(pass_phase)));

endmodule

bind sbank_conflict_replay sbank_conflict_replay_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_mask     (req_mask),
    .pass_valid   (pass_valid),
    .pass_phase   (pass_phase),
    .bank_en      (bank_en),
    .thread_valid (thread_valid),
    .done         (done)
);

// File: tb/test_sbank_conflict_replay.sv
`timescale 1ns/1ps
module test_sbank_conflict_replay;
    import sbank_pkg::*;

    typedef struct {
        logic [THREADS-1:0]            tv;
        logic [BANKS-1:0]              be;
        logic [BANKS-1:0][ROW_W-1:0]   rows;
        logic [BANKS-1:0][TID_W-1:0]   own;
        logic [PH_W-1:0]               ph;
        logic                          dn;
        string                         tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst;
    logic req_valid, req_ready, req_write;
    logic [1:0] req_size;
    logic [THREADS-1:0] req_mask;
    logic [THREADS*ADDR_W-1:0] req_addr;
    logic pass_valid, done;
    logic [PH_W-1:0] pass_phase;
    logic [BANKS-1:0] bank_en;
    logic [BANKS*ROW_W-1:0] bank_row;
    logic [BANKS*TID_W-1:0] bank_owner;
    logic [THREADS-1:0] thread_valid;

    logic [ADDR_W-1:0] addr_v [THREADS];
    exp_t sbq[$];
    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    bit done_seen = 1'b0;
    bit expect_empty = 1'b0;

    always #4 clk = ~clk;

    always_comb begin
        for (int t = 0; t < THREADS; t++) req_addr[t*ADDR_W +: ADDR_W] = addr_v[t];
    end

    sbank_conflict_replay i_sbank_conflict_replay (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_size(req_size), .req_mask(req_mask),
        .req_addr(req_addr), .pass_valid(pass_valid), .pass_phase(pass_phase),
        .bank_en(bank_en), .bank_row(bank_row), .bank_owner(bank_owner),
        .thread_valid(thread_valid), .done(done)
    );

    task automatic check(bit ok, string rq, string what, logic [255:0] act, logic [255:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, expv);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    // Expected passes derived from R1..R8: per phase, per bank group,
    // distinct rows in order of first appearance; pass k serves the k-th.
    task automatic build_expect(logic [THREADS-1:0] mask, int sz, bit wr, string rq);
        int wl, tpp, nph, np;
        int rl [BANKS][THREADS];
        int cnt [BANKS];
        int tg [THREADS];
        int tr [THREADS];
        exp_t lst[$];
        wl  = (sz == 0) ? 0 : (sz == 1) ? 1 : 2;
        tpp = THREADS >> wl;
        nph = 1 << wl;
        for (int t = 0; t < THREADS; t++) begin
            int w;
            w = int'(addr_v[t]) / WORD_BYTES;
            w = w - (w % (1 << wl));
            tg[t] = (w % BANKS) >> wl;
            tr[t] = w / BANKS;
        end
        for (int p = 0; p < nph; p++) begin
            for (int g = 0; g < BANKS; g++) cnt[g] = 0;
            np = 0;
            for (int t = p*tpp; t < (p+1)*tpp; t++) begin
                if (mask[t]) begin
                    bit seen;
                    seen = 1'b0;
                    for (int k = 0; k < cnt[tg[t]]; k++) if (rl[tg[t]][k] == tr[t]) seen = 1'b1;
                    if (!seen) begin
                        rl[tg[t]][cnt[tg[t]]] = tr[t];
                        cnt[tg[t]]++;
                        if (cnt[tg[t]] > np) np = cnt[tg[t]];
                    end
                end
            end
            for (int k = 0; k < np; k++) begin
                exp_t e;
                bit set [BANKS];
                e.tv = '0; e.be = '0; e.rows = '0; e.own = '0;
                e.ph = PH_W'(p); e.dn = 1'b0; e.tag = rq;
                for (int b = 0; b < BANKS; b++) set[b] = 1'b0;
                for (int g = 0; g < BANKS; g++) begin
                    if (cnt[g] > k) begin
                        for (int j = 0; j < (1 << wl); j++) begin
                            e.be[(g << wl) + j]   = 1'b1;
                            e.rows[(g << wl) + j] = ROW_W'(rl[g][k]);
                        end
                    end
                end
                for (int t = p*tpp; t < (p+1)*tpp; t++) begin
                    if (mask[t] && cnt[tg[t]] > k && rl[tg[t]][k] == tr[t]) begin
                        e.tv[t] = 1'b1;
                        for (int j = 0; j < (1 << wl); j++) begin
                            int b;
                            b = (tg[t] << wl) + j;
                            if (wr || !set[b]) e.own[b] = TID_W'(t);
                            set[b] = 1'b1;
                        end
                    end
                end
                lst.push_back(e);
            end
        end
        expect_empty = (lst.size() == 0);
        for (int i = 0; i < lst.size(); i++) begin
            exp_t e;
            e = lst[i];
            e.dn = (i == lst.size() - 1);
            sbq.push_back(e);
        end
    endtask

    task automatic run_req(logic [THREADS-1:0] mask, int sz, bit wr, string rq, bit poke);
        build_expect(mask, sz, wr, rq);
        done_seen = 1'b0;
        @(negedge clk);
        check(req_ready == 1'b1, "R10", "ready while idle", 256'(req_ready), 256'(1));
        req_valid = 1'b1; req_mask = mask; req_size = 2'(sz); req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
        if (poke) begin
            @(negedge clk);
            check(req_ready == 1'b0, "R10", "ready while busy", 256'(req_ready), 256'(0));
            req_valid = 1'b1; req_mask = 32'h0000_FFFF; req_size = 2'd0; req_write = 1'b0;
            @(negedge clk);
            req_valid = 1'b0;
        end
        for (int i = 0; i < 200 && !done_seen; i++) @(negedge clk);
        check(done_seen, "R9", "done reached", 256'(done_seen), 256'(1));
        check(sbq.size() == 0, "R4", "passes left unissued", 256'(sbq.size()), 256'(0));
        sbq.delete();
        repeat (3) @(negedge clk);
        check(!pass_valid && req_ready, "R10", "idle after done, stray request ignored",
              256'({pass_valid, req_ready}), 256'(2'b01));
    endtask

    // Monitor: compares each issued pass against the scoreboard head.
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (pass_valid) begin
                if (sbq.size() == 0) begin
                    check(1'b0, "R9", "unexpected pass", 256'(thread_valid), 256'(0));
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    check(thread_valid == e.tv, e.tag, "thread_valid", 256'(thread_valid), 256'(e.tv));
                    check(bank_en == e.be, "R3", "bank_en", 256'(bank_en), 256'(e.be));
                    check(bank_row == e.rows, "R1", "bank_row", 256'(bank_row), 256'(e.rows));
                    check(bank_owner == e.own, "R8", "bank_owner", 256'(bank_owner), 256'(e.own));
                    check(pass_phase == e.ph, "R5", "pass_phase", 256'(pass_phase), 256'(e.ph));
                    check(done == e.dn, "R9", "done on last pass", 256'(done), 256'(e.dn));
                end
            end else if (done) begin
                check(expect_empty, "R9", "done without a pass", 256'(done), 256'(0));
            end
            if (done) done_seen = 1'b1;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R9 watchdog actual=hung expected=finished");
        report();
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_size = 2'd0; req_mask = '0;
        for (int t = 0; t < THREADS; t++) addr_v[t] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready && !pass_valid && !done && bank_en == '0 && thread_valid == '0,
              "R11", "reset state", 256'({req_ready, pass_valid, done}), 256'(3'b100));

        // R1: linear words, one pass over all banks
        for (int t = 0; t < THREADS; t++) addr_v[t] = ADDR_W'(4*t + 256);
        run_req(32'hFFFF_FFFF, 0, 1'b0, "R1", 1'b0);
        // R2: distinct bytes of shared words
        for (int t = 0; t < THREADS; t++) addr_v[t] = ADDR_W'(t);
        run_req(32'hFFFF_FFFF, 0, 1'b0, "R2", 1'b0);
        // R2 / R8: every thread writes one word, highest wins
        for (int t = 0; t < THREADS; t++) addr_v[t] = ADDR_W'(64);
        run_req(32'hFFFF_FFFF, 0, 1'b1, "R2", 1'b0);
        // R8: partial mask, write then read of one word
        for (int t = 0; t < THREADS; t++) addr_v[t] = ADDR_W'(200 + (t % 4));
        run_req(32'h0000_0F0F, 0, 1'b1, "R8", 1'b0);
        run_req(32'h0000_0F0F, 0, 1'b0, "R8", 1'b0);
        // R4: 2-way conflict
        for (int t = 0; t < THREADS; t++) addr_v[t] = ADDR_W'(8*t);
        run_req(32'hFFFF_FFFF, 0, 1'b0, "R4", 1'b0);
        // R4 / R10: 32-way conflict with a request poked while busy
        for (int t = 0; t < THREADS; t++) addr_v[t] = ADDR_W'(128*t);
        run_req(32'hFFFF_FFFF, 0, 1'b1, "R4", 1'b1);
        // R7: partial mask with 4-way conflicts
        for (int t = 0; t < THREADS; t++) addr_v[t] = ADDR_W'((t % 4)*128 + (t / 4)*4);
        run_req(32'h5A5A_F00F, 0, 1'b0, "R7", 1'b0);
        // R5: 8-byte linear, two phases
        for (int t = 0; t < THREADS; t++) addr_v[t] = ADDR_W'(8*t);
        run_req(32'hFFFF_FFFF, 1, 1'b0, "R5", 1'b0);
        // R6: 8-byte conflict, unaligned low bits ignored
        for (int t = 0; t < THREADS; t++) addr_v[t] = ADDR_W'(128*t + 3);
        run_req(32'hFFFF_FFFF, 1, 1'b1, "R6", 1'b0);
        // R6: same banks across phases do not conflict
        for (int t = 0; t < THREADS; t++)
            addr_v[t] = (t < 16) ? ADDR_W'(8*t) : ADDR_W'(256 + 8*(t - 16));
        run_req(32'hFFFF_FFFF, 1, 1'b0, "R6", 1'b0);
        // R5: 16-byte linear, four phases
        for (int t = 0; t < THREADS; t++) addr_v[t] = ADDR_W'(16*t);
        run_req(32'hFFFF_FFFF, 2, 1'b0, "R5", 1'b0);
        // R5: size code 3 behaves as 16 bytes, with conflicts
        for (int t = 0; t < THREADS; t++) addr_v[t] = ADDR_W'((t % 2)*128 + 16*((t / 2) % 4) + 5);
        run_req(32'hFFFF_FFFF, 3, 1'b1, "R5", 1'b0);
        // R9: empty mask
        run_req(32'h0000_0000, 0, 1'b0, "R9", 1'b0);
        // mixed random traffic over a small address window
        for (int n = 0; n < 8; n++) begin
            int sz;
            sz = int'($urandom % 4);
            for (int t = 0; t < THREADS; t++) addr_v[t] = ADDR_W'($urandom % 512);
            run_req($urandom, sz, 1'($urandom % 2), "R3", 1'b0);
        end
        report();
    end

endmodule